// File: doc/BRIEF.md
# System Controller Register Bank

This block is a memory-mapped housekeeping controller for a processor subsystem. A host issues single-cycle 32-bit word accesses. The byte address is reduced to a word index, and the index selects one of a small set of registers. The registers cover the following:

- A GPIO input sampler, with output and interrupt-mask registers.
- Two identical up-counting compare timers.
- A debug scratchpad and a write-once debug lock flag.
- Read-only identity registers that report the clock frequency, the capabilities and a system identifier.

Two of the locations are command ports rather than storage. Any write to the system-identifier word raises a one-cycle system reset request. A write of the shutdown code to the configuration-port word raises a one-cycle shutdown request. The configuration-port word always reads back its ready flag.

The block drives three interrupt lines:

- The GPIO line is the level OR of the masked input bits.
- Each timer line pulses for one cycle when its counter reaches its compare value.

A timer without auto-restart then disables itself. A timer with auto-restart continues from zero. Read data is a combinational function of the address. Writes take effect at the clock edge where `bus_sel` and `bus_we` are both high.

Top module: `sysctl_top`

## Requirements
- R1: The word index is `bus_addr[ADDR_W-1:2]`, and the two low address bits are ignored. Indices not listed in this brief read as zero, and writes to them change no register and raise no request.
- R2: While reset is held, the reads are as follows:
  - index 16 reads 1 (ready).
  - index 31 reads `SYS_ID` (default 0x10014D31).
  - index 29 reads `CLK_HZ` (default 80000000).
  - index 30 reads `CAPS` (default 0).
  - index 0 reads the low `GPIO_W` bits of `STRAP` (default 1).
  - every other index reads 0.
- R3: Index 0 returns `gpio_pins` as registered on the previous clock edge. Writes to index 0 are ignored.
- R4: Index 1 (output) and index 2 (interrupt mask) store the low `GPIO_W` bits written and read back zero-extended. `gpio_out` drives the index 1 value.
- R5: `gpio_irq` is high exactly when the registered input ANDed with the mask is nonzero.
- R6: Timer k (k = 0, 1) occupies indices 4+4k (control), 5+4k (compare) and 6+4k (counter). Control bit 0 is enable and bit 1 is auto-restart. An enabled counter increments once per cycle. In the cycle after it equals compare, it returns to 0 and the timer's irq is high for one cycle. Starting from count 0, the irq is first seen cmp+1 cycles after the enabling write edge. The two timers are independent.
- R7: Without auto-restart, a compare match clears the enable bit, and the counter then holds 0 with no further irq.
- R8: With auto-restart, the timer stays enabled and fires every cmp+1 cycles.
- R9: Compare and counter are read/write. A counter write loads the counter, and counting continues from the written value.
- R10: Any write to index 21 sets its bit 0 to 1 whatever the data. The bit stays 1 until reset.
- R11: A write to index 31 leaves its value unchanged. It drives `sys_reset_req` high for exactly the cycle after the write edge.
- R12: A write to index 16 whose bits [15:0] equal 0x000E drives `sys_shutdown_req` high for the cycle after the write edge. Other values do nothing, and index 16 keeps reading 1.
- R13: Writes to indices 29 and 30 are ignored.
- R14: Index 20 is a 32-bit read/write scratchpad.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Access valid this cycle |
| bus_we | input | 1 | Access is a write |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| gpio_pins | input | GPIO_W | GPIO input pins |
| gpio_out | output | GPIO_W | GPIO output register |
| gpio_irq | output | 1 | Masked GPIO interrupt level |
| timer0_irq | output | 1 | Timer 0 match pulse |
| timer1_irq | output | 1 | Timer 1 match pulse |
| sys_reset_req | output | 1 | System reset request pulse |
| sys_shutdown_req | output | 1 | System shutdown request pulse |

## Verification
The bench builds the block with `GPIO_W` = 4 and the other parameters at their defaults. This width allows every pin pattern to be swept against every mask pattern, so the masked interrupt is checked for all 256 combinations. With the default `ADDR_W` of 7, the whole 32-word space can be swept: reset values and unmapped writes are checked at every index. Compare values from 0 to 6 are run on both timers in both modes. This covers the immediate match at compare 0, and with auto-restart the back-to-back irq at compare 0.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
  localparam int DATA_W = 32;
  localparam int N_TMR  = 2;

  // word indices
  localparam int IDX_GPIO_IN  = 0;
  localparam int IDX_GPIO_OUT = 1;
  localparam int IDX_GPIO_IEN = 2;
  localparam int IDX_T0_BASE  = 4;
  localparam int TMR_STRIDE   = 4;
  localparam int IDX_CFGPORT  = 16;
  localparam int IDX_SCRATCH  = 20;
  localparam int IDX_LOCK     = 21;
  localparam int IDX_CLKHZ    = 29;
  localparam int IDX_CAPS     = 30;
  localparam int IDX_SYSID    = 31;

  // offsets inside a timer group
  localparam int TMR_CTRL_OFS = 0;
  localparam int TMR_CMP_OFS  = 1;
  localparam int TMR_CNT_OFS  = 2;

  // control bits
  localparam int CTL_EN_BIT   = 0;
  localparam int CTL_AUTO_BIT = 1;

  localparam logic [15:0]       SHUTDOWN_CODE = 16'h000E;
  localparam logic [DATA_W-1:0] CFGPORT_READY = 32'h0000_0001;

  // next counter value: wrap to zero on a match, otherwise step by one
  function automatic logic [DATA_W-1:0] tmr_next(input logic [DATA_W-1:0] cnt,
                                                 input logic [DATA_W-1:0] cmp);
    return (cnt == cmp) ? '0 : cnt + 1'b1;
  endfunction

  function automatic logic is_shutdown_cmd(input logic [DATA_W-1:0] d);
    return d[15:0] == SHUTDOWN_CODE;
  endfunction

  function automatic int tmr_base(input int k);
    return IDX_T0_BASE + k * TMR_STRIDE;
  endfunction
endpackage

// File: rtl/sysctl_timer.sv
module sysctl_timer
  import sysctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ctrl,
  input  logic              wr_cmp,
  input  logic              wr_cnt,
  input  logic [DATA_W-1:0] wdata,
  output logic              en_q,
  output logic              auto_q,
  output logic [DATA_W-1:0] cmp_q,
  output logic [DATA_W-1:0] cnt_q,
  output logic              hit,
  output logic              irq
);
  // match event, visible to the checker
  assign hit = en_q && (cnt_q == cmp_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      auto_q <= 1'b0;
      cmp_q  <= '0;
      cnt_q  <= '0;
      irq    <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        en_q   <= wdata[CTL_EN_BIT];
        auto_q <= wdata[CTL_AUTO_BIT];
      end else if (hit && !auto_q) begin
        en_q <= 1'b0;
      end
      if (wr_cmp) cmp_q <= wdata;
      if (wr_cnt)    cnt_q <= wdata;
      else if (en_q) cnt_q <= tmr_next(cnt_q, cmp_q);
      irq <= hit;
    end
  end
endmodule

// File: rtl/sysctl_gpio.sv
module sysctl_gpio #(
  parameter int          GPIO_W = 8,
  parameter logic [31:0] STRAP  = 32'h0000_0001
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [GPIO_W-1:0] pins,
  input  logic              wr_out,
  input  logic              wr_ien,
  input  logic [GPIO_W-1:0] wdata,
  output logic [GPIO_W-1:0] in_q,
  output logic [GPIO_W-1:0] out_q,
  output logic [GPIO_W-1:0] ien_q,
  output logic              irq
);
  localparam logic [GPIO_W-1:0] STRAP_BITS = STRAP[GPIO_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_q  <= STRAP_BITS;
      out_q <= '0;
      ien_q <= '0;
    end else begin
      in_q <= pins;
      if (wr_out) out_q <= wdata;
      if (wr_ien) ien_q <= wdata;
    end
  end

  assign irq = |(in_q & ien_q);
endmodule

// File: rtl/sysctl_cmd.sv
module sysctl_cmd
  import sysctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_sysid,
  input  logic              wr_cfg,
  input  logic              wr_lock,
  input  logic              wr_scr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] scratch_q,
  output logic              lock_q,
  output logic              shut_hit,
  output logic              reset_req,
  output logic              shutdown_req
);
  // decoded shutdown command, visible to the checker
  assign shut_hit = wr_cfg && is_shutdown_cmd(wdata);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scratch_q    <= '0;
      lock_q       <= 1'b0;
      reset_req    <= 1'b0;
      shutdown_req <= 1'b0;
    end else begin
      if (wr_scr)  scratch_q <= wdata;
      if (wr_lock) lock_q    <= 1'b1;
      reset_req    <= wr_sysid;
      shutdown_req <= shut_hit;
    end
  end
endmodule

// File: rtl/sysctl_top.sv
module sysctl_top
  import sysctl_pkg::*;
#(
  parameter int          ADDR_W = 7,
  parameter int          GPIO_W = 8,
  parameter logic [31:0] STRAP  = 32'h0000_0001,
  parameter logic [31:0] SYS_ID = 32'h1001_4D31,
  parameter logic [31:0] CLK_HZ = 32'd80_000_000,
  parameter logic [31:0] CAPS   = 32'h0000_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [GPIO_W-1:0] gpio_pins,
  output logic [GPIO_W-1:0] gpio_out,
  output logic              gpio_irq,
  output logic              timer0_irq,
  output logic              timer1_irq,
  output logic              sys_reset_req,
  output logic              sys_shutdown_req
);
  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] widx;
  logic             wr;
  assign widx = bus_addr[ADDR_W-1:2];
  assign wr   = bus_sel && bus_we;

  // ---------------- GPIO ----------------
  logic              wr_gout, wr_gien;
  logic [GPIO_W-1:0] gin_q, gout_q, gien_q;
  assign wr_gout = wr && (widx == IDX_W'(IDX_GPIO_OUT));
  assign wr_gien = wr && (widx == IDX_W'(IDX_GPIO_IEN));

  sysctl_gpio #(.GPIO_W(GPIO_W), .STRAP(STRAP)) u_gpio (
    .clk   (clk),
    .rst_n (rst_n),
    .pins  (gpio_pins),
    .wr_out(wr_gout),
    .wr_ien(wr_gien),
    .wdata (bus_wdata[GPIO_W-1:0]),
    .in_q  (gin_q),
    .out_q (gout_q),
    .ien_q (gien_q),
    .irq   (gpio_irq)
  );
  assign gpio_out = gout_q;

  // ---------------- timers ----------------
  logic [N_TMR-1:0] t_wrc, t_wrp, t_wrn, t_en, t_auto, t_hit, t_irq;
  logic [DATA_W-1:0] t_cmp [N_TMR];
  logic [DATA_W-1:0] t_cnt [N_TMR];

  for (genvar k = 0; k < N_TMR; k++) begin : g_tmr
    localparam int BASE = tmr_base(k);
    assign t_wrc[k] = wr && (widx == IDX_W'(BASE + TMR_CTRL_OFS));
    assign t_wrp[k] = wr && (widx == IDX_W'(BASE + TMR_CMP_OFS));
    assign t_wrn[k] = wr && (widx == IDX_W'(BASE + TMR_CNT_OFS));

    sysctl_timer u_tmr (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_ctrl(t_wrc[k]),
      .wr_cmp (t_wrp[k]),
      .wr_cnt (t_wrn[k]),
      .wdata  (bus_wdata),
      .en_q   (t_en[k]),
      .auto_q (t_auto[k]),
      .cmp_q  (t_cmp[k]),
      .cnt_q  (t_cnt[k]),
      .hit    (t_hit[k]),
      .irq    (t_irq[k])
    );
  end

  assign timer0_irq = t_irq[0];
  assign timer1_irq = t_irq[1];

  // ---------------- command / debug ----------------
  logic              wr_sysid, wr_cfg, wr_lock, wr_scr;
  logic [DATA_W-1:0] scratch_q;
  logic              lock_q, shut_hit;
  assign wr_sysid = wr && (widx == IDX_W'(IDX_SYSID));
  assign wr_cfg   = wr && (widx == IDX_W'(IDX_CFGPORT));
  assign wr_lock  = wr && (widx == IDX_W'(IDX_LOCK));
  assign wr_scr   = wr && (widx == IDX_W'(IDX_SCRATCH));

  sysctl_cmd u_cmd (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_sysid    (wr_sysid),
    .wr_cfg      (wr_cfg),
    .wr_lock     (wr_lock),
    .wr_scr      (wr_scr),
    .wdata       (bus_wdata),
    .scratch_q   (scratch_q),
    .lock_q      (lock_q),
    .shut_hit    (shut_hit),
    .reset_req   (sys_reset_req),
    .shutdown_req(sys_shutdown_req)
  );

  // ---------------- read mux ----------------
  always_comb begin
    bus_rdata = '0;
    case (int'(widx))
      IDX_GPIO_IN:  bus_rdata[GPIO_W-1:0] = gin_q;
      IDX_GPIO_OUT: bus_rdata[GPIO_W-1:0] = gout_q;
      IDX_GPIO_IEN: bus_rdata[GPIO_W-1:0] = gien_q;
      IDX_T0_BASE + TMR_CTRL_OFS: begin
        bus_rdata[CTL_EN_BIT]   = t_en[0];
        bus_rdata[CTL_AUTO_BIT] = t_auto[0];
      end
      IDX_T0_BASE + TMR_CMP_OFS: bus_rdata = t_cmp[0];
      IDX_T0_BASE + TMR_CNT_OFS: bus_rdata = t_cnt[0];
      IDX_T0_BASE + TMR_STRIDE + TMR_CTRL_OFS: begin
        bus_rdata[CTL_EN_BIT]   = t_en[1];
        bus_rdata[CTL_AUTO_BIT] = t_auto[1];
      end
      IDX_T0_BASE + TMR_STRIDE + TMR_CMP_OFS: bus_rdata = t_cmp[1];
      IDX_T0_BASE + TMR_STRIDE + TMR_CNT_OFS: bus_rdata = t_cnt[1];
      IDX_CFGPORT: bus_rdata = CFGPORT_READY;
      IDX_SCRATCH: bus_rdata = scratch_q;
      IDX_LOCK:    bus_rdata[0] = lock_q;
      IDX_CLKHZ:   bus_rdata = CLK_HZ;
      IDX_CAPS:    bus_rdata = CAPS;
      IDX_SYSID:   bus_rdata = SYS_ID;
      default:     bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/sysctl_chk.sv
module sysctl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] t_hit,
  input logic [1:0] t_en,
  input logic [1:0] t_auto,
  input logic [1:0] t_wrc,
  input logic [1:0] t_irq,
  input logic       wr_sysid,
  input logic       shut_hit,
  input logic       lock_q,
  input logic       reset_req,
  input logic       shutdown_req
);
  for (genvar k = 0; k < 2; k++) begin : g_tc
    // R6
    irq_follows_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      t_irq[k] |-> $past(t_hit[k]));
    // R7
    oneshot_stops_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (t_hit[k] && !t_auto[k] && !t_wrc[k]) |=> !t_en[k]);
    // R8
    autorestart_runs_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (t_hit[k] && t_auto[k] && !t_wrc[k]) |=> t_en[k]);
  end

  // R10
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> lock_q);

  // R11
  reset_req_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |-> $past(wr_sysid));

  // R12
  shutdown_req_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown_req |-> $past(shut_hit));
endmodule

bind sysctl_top sysctl_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .t_hit       (t_hit),
  .t_en        (t_en),
  .t_auto      (t_auto),
  .t_wrc       (t_wrc),
  .t_irq       (t_irq),
  .wr_sysid    (wr_sysid),
  .shut_hit    (shut_hit),
  .lock_q      (lock_q),
  .reset_req   (sys_reset_req),
  .shutdown_req(sys_shutdown_req)
);

// File: tb/tb_sysctl_top.sv
`timescale 1ns/1ps
module tb_sysctl_top;
  localparam int GW = 4;
  localparam logic [31:0] E_ID  = 32'h1001_4D31;
  localparam logic [31:0] E_HZ  = 32'd80_000_000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_sel = 1'b0, bus_we = 1'b0;
  logic [6:0]    bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [GW-1:0] gpio_pins = '0;
  logic [GW-1:0] gpio_out;
  logic          gpio_irq, timer0_irq, timer1_irq, sys_reset_req, sys_shutdown_req;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  sysctl_top #(.GPIO_W(GW)) dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .gpio_pins(gpio_pins), .gpio_out(gpio_out), .gpio_irq(gpio_irq),
    .timer0_irq(timer0_irq), .timer1_irq(timer1_irq),
    .sys_reset_req(sys_reset_req), .sys_shutdown_req(sys_shutdown_req)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic wrb(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic wr(input int idx, input logic [31:0] d);
    wrb(7'(idx * 4), d);
  endtask

  task automatic rd(input int idx, output logic [31:0] d);
    @(negedge clk);
    bus_addr = 7'(idx * 4);
    #1 d = bus_rdata;
  endtask

  function automatic logic [31:0] exp_reset(input int idx);
    case (idx)
      0:  return 32'h1;
      16: return 32'h1;
      29: return E_HZ;
      30: return 32'h0;
      31: return E_ID;
      default: return 32'h0;
    endcase
  endfunction

  function automatic bit is_mapped(input int idx);
    return idx inside {0, 1, 2, 4, 5, 6, 8, 9, 10, 16, 20, 21, 29, 30, 31};
  endfunction

  function automatic logic tirq(input int t);
    return (t == 0) ? timer0_irq : timer1_irq;
  endfunction

  task automatic timer_run(input int t, input int cmp, input bit auto_r);
    int base = 4 + 4 * t;
    int first = -1, second = -1, other = 0;
    logic [31:0] v;
    wr(base + 2, 0);
    wr(base + 1, cmp);
    wr(base, {30'b0, auto_r, 1'b1});
    for (int n = 1; n <= 2 * (cmp + 1) + 2; n++) begin
      @(negedge clk); #1;
      if (tirq(t)) begin
        if (first < 0) first = n;
        else if (second < 0) second = n;
      end
      if (tirq(1 - t)) other++;
    end
    chk($sformatf("R6 t%0d cmp%0d first irq cycle", t, cmp), first, cmp + 1);
    chk($sformatf("R6 t%0d other timer quiet", t), other, 0);
    if (auto_r) begin
      chk($sformatf("R8 t%0d cmp%0d second irq cycle", t, cmp), second, 2 * (cmp + 1));
      rd(base, v);
      chk("R8 enable kept", v[0], 1'b1);
      wr(base, 0);
    end else begin
      chk($sformatf("R7 t%0d cmp%0d no second irq", t, cmp), second, -1);
      rd(base, v);
      chk("R7 enable cleared", v[0], 1'b0);
      rd(base + 2, v);
      chk("R7 counter held at zero", v, 0);
    end
  endtask

  initial begin
    logic [31:0] v;
    // R2 reset values over the full map
    repeat (3) @(posedge clk);
    for (int i = 0; i < 32; i++) begin
      rd(i, v);
      chk($sformatf("R2 reset idx %0d", i), v, exp_reset(i));
    end
    @(negedge clk); rst_n = 1'b1;

    // R14 scratchpad, R1 low address bits ignored
    wr(20, 32'hA5C3_0F96);
    rd(20, v); chk("R14 scratch", v, 32'hA5C3_0F96);
    wrb(7'(20 * 4 + 3), 32'h1234_5678);
    rd(20, v); chk("R1 low addr bits ignored", v, 32'h1234_5678);

    // R4 gpio out / mask
    wr(1, 32'hFFFF_FFFA);
    rd(1, v); chk("R4 gpio out read", v, 32'hA);
    chk("R4 gpio_out pins", gpio_out, 4'hA);
    wr(2, 32'hF000_0003);
    rd(2, v); chk("R4 gpio mask read", v, 32'h3);

    // R3 / R5 exhaustive pin x mask sweep
    for (int p = 0; p < 16; p++) begin
      for (int e = 0; e < 16; e++) begin
        gpio_pins = 4'(p);
        wr(2, e);
        rd(0, v);
        chk($sformatf("R3 gpio in p=%0d", p), v, p);
        chk($sformatf("R5 gpio irq p=%0d e=%0d", p, e), gpio_irq, |(4'(p) & 4'(e)));
      end
    end
    gpio_pins = 4'h9;
    wr(0, 32'h6);
    rd(0, v); chk("R3 write to input ignored", v, 32'h9);

    // R10 lock
    rd(21, v); chk("R10 lock clear", v, 0);
    wr(21, 0);
    rd(21, v); chk("R10 lock set by zero write", v, 1);
    wr(21, 32'hFFFF_FFFF);
    rd(21, v); chk("R10 lock stays", v, 1);

    // R11 reset request
    wr(31, 32'h0);
    chk("R11 reset pulse", sys_reset_req, 1'b1);
    chk("R11 no shutdown", sys_shutdown_req, 1'b0);
    @(negedge clk);
    chk("R11 reset pulse one cycle", sys_reset_req, 1'b0);
    rd(31, v); chk("R11 id unchanged", v, E_ID);

    // R12 shutdown command
    wr(16, 32'h0000_1234);
    chk("R12 other value no shutdown", sys_shutdown_req, 1'b0);
    wr(16, 32'hABCD_000E);
    chk("R12 shutdown pulse", sys_shutdown_req, 1'b1);
    chk("R12 no reset", sys_reset_req, 1'b0);
    @(negedge clk);
    chk("R12 shutdown one cycle", sys_shutdown_req, 1'b0);
    rd(16, v); chk("R12 ready reads 1", v, 1);

    // R13 read-only identity
    wr(29, 32'h0); wr(30, 32'hFFFF_FFFF);
    rd(29, v); chk("R13 freq", v, E_HZ);
    rd(30, v); chk("R13 caps", v, 0);

    // R1 unmapped sweep
    for (int i = 0; i < 32; i++) begin
      if (!is_mapped(i)) begin
        wrb(7'(i * 4 + 1), 32'hFFFF_FFFF);
        chk($sformatf("R1 unmapped %0d no request", i), {sys_reset_req, sys_shutdown_req}, 0);
        rd(i, v); chk($sformatf("R1 unmapped %0d reads 0", i), v, 0);
      end
    end
    rd(20, v); chk("R1 scratch intact", v, 32'h1234_5678);
    rd(1, v);  chk("R1 gpio out intact", v, 32'hA);

    // R9 counter/compare access and counting from written value
    wr(6, 32'd5);
    rd(6, v); chk("R9 counter write", v, 5);
    wr(5, 32'd10);
    rd(5, v); chk("R9 compare read", v, 10);
    wr(4, 32'h1);
    rd(6, v); chk("R9 counts from written value", v, 6);
    wr(4, 32'h0);

    // R6 R7 R8 sweeps on both timers
    for (int t = 0; t < 2; t++)
      for (int c = 0; c <= 6; c++)
        for (int a = 0; a < 2; a++)
          timer_run(t, c, a[0]);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule